// File: doc/BRIEF.md
# Trimmed One-Second Tick Divider

This block turns a free-running low-frequency oscillator clock into a single-cycle strobe once per second. It also applies a small digital rate correction. A three-bit trim code selects a correction of up to three steps of 10 ppm, in either direction. The correction never changes the clock. It changes how many oscillator cycles make up a second: some seconds are one count shorter or one count longer than nominal, so the error averages out over many seconds.

Each second, a fixed-point fractional accumulator adds the selected correction, expressed in counts. When the sum passes a whole count, the carry adjusts the length of the following second by one count. A positive correction means the oscillator runs slow, so the second is shortened. A negative correction means it runs fast, so the second is lengthened. The trim code is sampled only at the boundary between seconds. The accumulator carries its remainder across code changes and is cleared only by reset. The downstream calendar logic simply counts the strobes.

Top module: `ppm_tick_gen`

## Requirements
- R1: `secTick` is high for exactly one clock cycle per second. The number of cycles from one strobe to the next equals the length of that second.
- R2: Codes 000 and 100 give a correction of zero. With either code held, every second is exactly `DIV_COUNT` cycles long.
- R3: The magnitude of a code is (bit 1) + 2×(bit 2… low bit 0), that is: code bit 1 is worth one step and code bit 0 is worth two steps. At each boundary, the accumulator adds magnitude × floor(`STEP_PPM`×`DIV_COUNT`×2^`FRAC_BITS` / `PPM_DENOM`). The accumulator is `FRAC_BITS` wide, and a carry out of it is a whole count.
- R4: When code bit 2 is 0 and the boundary addition carries, the next second is `DIV_COUNT`−1 cycles long.
- R5: When code bit 2 is 1 and the boundary addition carries, the next second is `DIV_COUNT`+1 cycles long.
- R6: The code is sampled only in the last cycle of a second and sets the length of the following second. A code change during a second has no effect on the length of that second.
- R7: A code change does not clear the accumulator. The remainder from earlier seconds counts toward the next carry, including when the sign changes.
- R8: Synchronous reset keeps `secTick` low and clears both the divider and the accumulator. The first strobe after reset comes `DIV_COUNT` cycles after the last reset cycle.
- R9: The length of a second is always within `DIV_COUNT`−1 to `DIV_COUNT`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| trimCode | input | 3 | Bit 2 is the sign (1 = negative). Bit 1 is one step, bit 0 is two steps |
| secTick | output | 1 | One-cycle strobe at the end of every second |

## Verification
The hardest case to reach from the ports is a carry that depends on a remainder left by an earlier code, because the accumulator is not visible. The stimulus builds up a known remainder with one code. It then switches to a code of the opposite sign, so that the next carry appears only if the remainder survived, and the carry shows up as a one-cycle change in a strobe interval. The bench is built with a short second and a power-of-two denominator, so the per-step increment is exact. It then runs a bit-exact accumulator model over a table of codes, with a mid-second code change and a reset in the middle of a second.

// File: rtl/ppm_tick_pkg.sv
package ppm_tick_pkg;

  // Strobes from the second counter to the correction datapath
  typedef struct packed {
    logic secEnd;    // last cycle of the current second
    logic secStart;  // first cycle of a second
  } tickStrobe_t;

  // Magnitude in steps: bit 1 weighs one step, bit 0 weighs two steps
  function automatic logic [1:0] trimMag(input logic [2:0] code);
    return {code[0], code[1]};
  endfunction

  function automatic logic trimNeg(input logic [2:0] code);
    return code[2];
  endfunction

endpackage

// File: rtl/ppm_tick_decode.sv
module ppm_tick_decode #(
  parameter int FRAC_BITS = 20,
  parameter int INC_UNIT  = 343597
) (
  input  logic [2:0]           trimCode,
  output logic [FRAC_BITS-1:0] incStep,
  output logic                 negDir
);
  import ppm_tick_pkg::*;

  localparam logic [FRAC_BITS-1:0] STEP1 = FRAC_BITS'(INC_UNIT);
  localparam logic [FRAC_BITS-1:0] STEP2 = FRAC_BITS'(2 * INC_UNIT);
  localparam logic [FRAC_BITS-1:0] STEP3 = FRAC_BITS'(3 * INC_UNIT);

  logic [1:0] mag;

  always_comb begin
    mag    = trimMag(trimCode);
    negDir = trimNeg(trimCode);
    unique case (mag)
      2'd0:    incStep = '0;
      2'd1:    incStep = STEP1;
      2'd2:    incStep = STEP2;
      default: incStep = STEP3;
    endcase
  end

endmodule

// File: rtl/ppm_tick_datapath.sv
module ppm_tick_datapath #(
  parameter int DIV_COUNT = 32768,
  parameter int FRAC_BITS = 20,
  parameter int CNT_W     = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ppm_tick_pkg::tickStrobe_t strobe,
  input  logic [FRAC_BITS-1:0]      incStep,
  input  logic                      negDir,
  output logic [CNT_W-1:0]          lastIdx
);
  localparam logic [CNT_W-1:0] NOM_LAST  = CNT_W'(DIV_COUNT - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(DIV_COUNT - 2);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(DIV_COUNT);

  logic [FRAC_BITS-1:0] accQ;
  logic [FRAC_BITS:0]   accSum;
  logic                 carry;
  logic [CNT_W-1:0]     nextLast;

  always_comb begin
    accSum = {1'b0, accQ} + {1'b0, incStep};
    carry  = accSum[FRAC_BITS];
    if (!carry)      nextLast = NOM_LAST;
    else if (negDir) nextLast = LONG_LAST;
    else             nextLast = SHORT_LAST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ    <= '0;
      lastIdx <= NOM_LAST;
    end else if (strobe.secEnd) begin
      accQ    <= accSum[FRAC_BITS-1:0];
      lastIdx <= nextLast;
    end
  end

  // R9: length never leaves the one-count window
  p_len_window_r9: assert property (@(posedge clk) disable iff (rst)
    (lastIdx >= SHORT_LAST) && (lastIdx <= LONG_LAST));

  // R6: state only moves at a second boundary
  p_hold_mid_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe.secEnd |=> $stable(accQ) && $stable(lastIdx));

  // R2: zero correction always yields the nominal length
  p_zero_nominal_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.secEnd && (incStep == '0) |=> lastIdx == NOM_LAST);

  // R4: positive correction never lengthens
  p_pos_short_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.secEnd && !negDir |=> lastIdx <= NOM_LAST);

  // R5: negative correction never shortens
  p_neg_long_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.secEnd && negDir |=> lastIdx >= NOM_LAST);

endmodule

// File: rtl/ppm_tick_ctrl.sv
module ppm_tick_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CNT_W-1:0]          lastIdx,
  output ppm_tick_pkg::tickStrobe_t strobe,
  output logic                      secTick
);
  logic [CNT_W-1:0] cntQ;
  logic             endNow;

  always_comb begin
    endNow          = (cntQ == lastIdx);
    strobe.secEnd   = endNow;
    strobe.secStart = (cntQ == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ    <= '0;
      secTick <= 1'b0;
    end else begin
      cntQ    <= endNow ? '0 : cntQ + 1'b1;
      secTick <= endNow;
    end
  end

  // R1: strobe is a single cycle wide
  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    secTick |=> !secTick);

  // R1: a strobe is always followed by a fresh count
  p_tick_restart_r1: assert property (@(posedge clk) disable iff (rst)
    secTick |-> strobe.secStart);

  // R9: the count never runs past the programmed last index
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cntQ <= lastIdx);

endmodule

// File: rtl/ppm_tick_gen.sv
module ppm_tick_gen #(
  parameter int DIV_COUNT = 32768,
  parameter int STEP_PPM  = 10,
  parameter int PPM_DENOM = 1000000,
  parameter int FRAC_BITS = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] trimCode,
  output logic       secTick
);
  import ppm_tick_pkg::*;

  localparam int CNT_W = $clog2(DIV_COUNT + 2);
  localparam longint SCALED =
    longint'(STEP_PPM) * longint'(DIV_COUNT) * (longint'(1) <<< FRAC_BITS);
  localparam int INC_UNIT = int'(SCALED / longint'(PPM_DENOM));

  tickStrobe_t          strobe;
  logic [FRAC_BITS-1:0] incStep;
  logic                 negDir;
  logic [CNT_W-1:0]     lastIdx;

  ppm_tick_decode #(.FRAC_BITS(FRAC_BITS), .INC_UNIT(INC_UNIT)) decode_i (
    .trimCode(trimCode),
    .incStep (incStep),
    .negDir  (negDir)
  );

  ppm_tick_datapath #(.DIV_COUNT(DIV_COUNT), .FRAC_BITS(FRAC_BITS), .CNT_W(CNT_W)) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .incStep(incStep),
    .negDir (negDir),
    .lastIdx(lastIdx)
  );

  ppm_tick_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .lastIdx(lastIdx),
    .strobe (strobe),
    .secTick(secTick)
  );

endmodule

// File: tb/ppm_tick_gen_tb_top.sv
`timescale 1ns/1ps
module ppm_tick_gen_tb_top;
  localparam int DIV   = 16;
  localparam int DENOM = 1024;
  localparam int FRAC  = 16;
  localparam int ONE   = 1 << FRAC;
  localparam int UNIT  = (10 * DIV * ONE) / DENOM;  // 10240

  // row = {code, seconds}
  localparam int NROWS = 8;
  localparam logic [10:0] VEC [NROWS] = '{
    {3'b000, 8'd3}, {3'b100, 8'd3}, {3'b010, 8'd7}, {3'b001, 8'd5},
    {3'b011, 8'd5}, {3'b110, 8'd7}, {3'b101, 8'd5}, {3'b111, 8'd5}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] trimCode = 3'b000;
  logic       secTick;

  int total = 0;
  int fails = 0;
  int accM = 0;
  int expNext = DIV;

  always #4 clk = ~clk;

  ppm_tick_gen #(.DIV_COUNT(DIV), .STEP_PPM(10), .PPM_DENOM(DENOM), .FRAC_BITS(FRAC))
    dut_i (.clk(clk), .rst(rst), .trimCode(trimCode), .secTick(secTick));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of the boundary update for the code seen at that boundary
  task automatic advance(input logic [2:0] code);
    int mag = int'(code[1]) + 2 * int'(code[0]);
    accM += mag * UNIT;
    if (accM >= ONE) begin
      accM -= ONE;
      expNext = code[2] ? DIV + 1 : DIV - 1;
    end else begin
      expNext = DIV;
    end
  endtask

  // Count cycles to the next strobe; optionally swap the code mid-second
  task automatic measure(input string req, input int swapAt, input logic [2:0] swapCode);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == swapAt) trimCode = swapCode;
      if (n == 1 && expNext > 1) check(secTick == 1'b0, "R1", int'(secTick), 0);
    end while (!secTick && n < 4 * DIV);
    check(secTick && n == expNext, req, n, expNext);
  endtask

  task automatic runSec(input logic [2:0] code, input string req);
    trimCode = code;
    measure(req, 0, 3'b000);
    advance(code);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(secTick == 1'b0, "R8", int'(secTick), 0);
    rst = 1'b0;
    accM = 0;
    expNext = DIV;
    measure("R8", 0, 3'b000);
    advance(trimCode);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    doReset();

    // Table walk: R2 for zero codes, R3/R4 positive, R3/R5 negative
    for (int r = 0; r < NROWS; r++) begin
      logic [2:0] c = VEC[r][10:8];
      for (int s = 0; s < int'(VEC[r][7:0]); s++)
        runSec(c, (c[1:0] == 2'b00) ? "R2" : (c[2] ? "R3/R5" : "R3/R4"));
    end

    // R7: remainder from a positive code makes a negative code carry early
    trimCode = 3'b000;
    doReset();
    runSec(3'b011, "R7");
    runSec(3'b011, "R7");
    runSec(3'b110, "R7");
    runSec(3'b000, "R7");   // expect DIV+1 here (71680 wraps)
    check(accM == 71680 - ONE, "R7", accM, 71680 - ONE);

    // R6: code swapped mid-second; current second unaffected, boundary uses new code
    trimCode = 3'b000;
    doReset();
    runSec(3'b011, "R6");
    runSec(3'b011, "R6");
    trimCode = 3'b000;
    measure("R6", 5, 3'b111);   // boundary sees 111 -> 61440+30720 carries, negative
    advance(3'b111);
    runSec(3'b000, "R6");       // expect DIV+1
    check(expNext == DIV, "R6", expNext, DIV);

    // R8: reset in the middle of a second
    runSec(3'b001, "R8");
    repeat (5) @(negedge clk);
    trimCode = 3'b000;
    doReset();
    runSec(3'b000, "R8");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule